// File: doc/BRIEF.md
# Halt-Aware Serial Bus Address Responder

This block is the address-phase front end of a two-wire serial slave. The slave lives in a device whose core clock can be stopped while it sleeps. The block runs on an always-on oversampling clock. It passes the SCL and SDA lines through a two-flop synchronizer and finds START and STOP conditions. It then shifts in the eight bits that follow a START: the seven address bits and the direction bit.

While the core is asleep, any change on either line raises a wake request. That request stays up until the core reports that it is active. An address frame that began while the core was asleep is left unacknowledged, so the master sees a NACK, sends STOP and retries. The retry arrives once the core is awake, and a matching address is then acknowledged. The byte 0b00000001 serves only as a wake trigger and is never acknowledged.

After an acknowledged address, the block can hold SCL low until the core reports ready. Both line outputs are open-drain pull enables, where 1 means pull the line low.

The state machine has six states:
- IDLE waits for a START.
- ADDR counts eight SCL rising edges.
- ACK_WAIT waits for the SCL fall that ends the eighth bit. It then moves to ACK_DRIVE if the address is to be acknowledged and to PASS if not.
- ACK_DRIVE holds SDA low through the ninth clock. At the SCL fall that ends it, the machine moves to PASS if the core is ready and to STRETCH if it is not.
- STRETCH holds SCL low and moves to PASS when the core reports ready.
- PASS ignores the data phase.

Two transitions apply from any state: a START goes to ADDR, and a STOP goes to IDLE.

Top module: `bus_wake_responder`

## Requirements
- R1: A START is SDA falling while the synchronized SCL is high, and only a START moves the machine from IDLE into address reception. Clocking a full address with no START produces no acknowledge.
- R2: While `core_active` is 0, any edge on either synchronized line sets `wake_req` within 4 clock cycles. `wake_req` stays at 1 until `core_active` is 1, and it is 0 whenever `core_active` was 1 in the previous cycle.
- R3: The block samples `core_active` at START. If it was 0, that frame is never acknowledged, even if the core wakes during the frame.
- R4: If `core_active` was 1 at START and the byte's upper seven bits equal `OWN_ADDR`, then `sda_pull` is 1 from the SCL fall that ends the eighth bit until the next SCL fall. This covers the whole high phase of the ninth clock.
- R5: The byte 0x01 (address 0, direction bit 1) wakes the device and is never acknowledged, even when `OWN_ADDR` is 0.
- R6: A byte whose upper seven bits differ from `OWN_ADDR` is never acknowledged, whether the core is asleep or active.
- R7: The block stretches SCL after an acknowledged address if `core_ready` is 0 at the SCL fall that ends the ninth clock. In that case `scl_pull` is 1 until `core_ready` is 1, and it drops within 2 cycles after that.
- R8: A repeated START restarts bit counting from zero, and a full matching address after it is acknowledged. A STOP during an address returns the machine to IDLE, and no acknowledge follows.
- R9: Both outputs only ever request a pull low. After reset, `sda_pull`, `scl_pull` and `wake_req` are 0, and `sda_pull` and `scl_pull` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| core_active | input | 1 | Core clock running (1) or halted (0) |
| core_ready | input | 1 | Core can accept the transfer; releases a stretch |
| wake_req | output | 1 | Wake request to the power controller |
| scl_pull | output | 1 | Pull SCL low (open-drain enable) |
| sda_pull | output | 1 | Pull SDA low (open-drain enable) |

## Verification
The hardest case to reach is a core that wakes partway through an address frame. The frame must still be refused, because the power state was latched at START, and only the retry that follows may be acknowledged. The bench drives `core_active` from inside the frame task, raising it after a chosen bit. It then runs a STOP and a second, identical frame, and compares the acknowledge seen on the modelled open-drain line in each of the two frames. A second case that is hard to reach is a stretch held against a master that has already released SCL. The bench models the wired-AND line, releases its own SCL while `core_ready` is low, and watches the resolved line level.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
    localparam int ADDR_W     = 7;
    localparam int FRAME_BITS = ADDR_W + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam logic [FRAME_BITS-1:0] WAKE_BYTE = 8'h01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_STRETCH,
        ST_PASS
    } bwr_state_e;
endpackage

// File: rtl/bwr_sync.sv
module bwr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = STAGES * WIDTH;

    logic [CHAIN_W-1:0] chain;

    // Idle bus level is high, so the chain resets to all ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
    end

    assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/bwr_edge_detect.sv
module bwr_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    input  logic core_active,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt,
    output logic activity,
    output logic wake_req
);
    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    // SDA may only change while SCL is low, unless it marks a condition.
    assign start_evt = sda_p & ~sda_s & scl_s & scl_p;
    assign stop_evt  = ~sda_p & sda_s & scl_s & scl_p;
    assign activity  = (scl_s ^ scl_p) | (sda_s ^ sda_p);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           wake_req <= 1'b0;
        else if (core_active) wake_req <= 1'b0;
        else                  wake_req <= wake_req | activity;
    end
endmodule

// File: rtl/bwr_addr_fsm.sv
module bwr_addr_fsm
    import bwr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h3A
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_evt,
    input  logic                  stop_evt,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  sda_s,
    input  logic                  core_active,
    input  logic                  core_ready,
    output logic [FRAME_BITS-1:0] addr_byte,
    output logic                  sda_pull,
    output logic                  scl_pull
);
    bwr_state_e state;
    bwr_state_e state_nx;

    logic [CNT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] shift_q;
    logic                  halted_at_start;
    logic                  ack_ok;
    logic                  last_bit;

    assign last_bit = scl_rise && (bit_cnt == CNT_W'(FRAME_BITS - 1));
    assign ack_ok   = !halted_at_start
                   && (addr_byte[FRAME_BITS-1:1] == OWN_ADDR)
                   && (addr_byte != WAKE_BYTE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (stop_evt) begin
            state_nx = ST_IDLE;
        end else if (start_evt) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (last_bit) state_nx = ST_ACK_WAIT;
                ST_ACK_WAIT:  if (scl_fall) state_nx = ack_ok ? ST_ACK_DRIVE : ST_PASS;
                ST_ACK_DRIVE: if (scl_fall) state_nx = core_ready ? ST_PASS : ST_STRETCH;
                ST_STRETCH:   if (core_ready) state_nx = ST_PASS;
                ST_PASS:      state_nx = ST_PASS;
            endcase
        end
    end

    // Bit counter, shifter and power-state latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt         <= '0;
            shift_q         <= '0;
            addr_byte       <= '0;
            halted_at_start <= 1'b1;
        end else if (start_evt) begin
            bit_cnt         <= '0;
            shift_q         <= '0;
            halted_at_start <= !core_active;
        end else if (state == ST_ADDR && scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            shift_q <= {shift_q[FRAME_BITS-2:0], sda_s};
            if (last_bit) addr_byte <= {shift_q[FRAME_BITS-2:0], sda_s};
        end
    end

    // Output decode: pull enables only
    always_comb begin
        sda_pull = 1'b0;
        scl_pull = 1'b0;
        unique case (state)
            ST_ACK_DRIVE: sda_pull = 1'b1;
            ST_STRETCH:   scl_pull = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/bus_wake_responder.sv
module bus_wake_responder
    import bwr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR    = 7'h3A,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic core_active,
    input  logic core_ready,
    output logic wake_req,
    output logic scl_pull,
    output logic sda_pull
);
    logic                  scl_s;
    logic                  sda_s;
    logic                  scl_rise;
    logic                  scl_fall;
    logic                  start_evt;
    logic                  stop_evt;
    logic                  activity;
    logic [FRAME_BITS-1:0] addr_byte;

    bwr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     ({scl_s, sda_s})
    );

    bwr_edge_detect u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s       (scl_s),
        .sda_s       (sda_s),
        .core_active (core_active),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .activity    (activity),
        .wake_req    (wake_req)
    );

    bwr_addr_fsm #(.OWN_ADDR(OWN_ADDR)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .sda_s       (sda_s),
        .core_active (core_active),
        .core_ready  (core_ready),
        .addr_byte   (addr_byte),
        .sda_pull    (sda_pull),
        .scl_pull    (scl_pull)
    );
endmodule

// File: rtl/bwr_checker.sv
module bwr_checker
    import bwr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] OWN_ADDR = 7'h3A
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  activity,
    input logic                  core_active,
    input logic                  core_ready,
    input logic                  wake_req,
    input logic                  sda_pull,
    input logic                  scl_pull,
    input logic [FRAME_BITS-1:0] addr_byte
);
    p_wake_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (activity && !core_active) |=> wake_req);

    p_wake_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_active |=> !wake_req);

    p_ack_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (addr_byte[FRAME_BITS-1:1] == OWN_ADDR));

    p_no_wake_byte_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> (addr_byte != WAKE_BYTE));

    p_ack_starts_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    p_stretch_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull && core_ready) |=> !scl_pull);

    p_single_pull_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(sda_pull && scl_pull));
endmodule

bind bus_wake_responder bwr_checker #(.OWN_ADDR(OWN_ADDR)) u_bwr_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .activity    (activity),
    .core_active (core_active),
    .core_ready  (core_ready),
    .wake_req    (wake_req),
    .sda_pull    (sda_pull),
    .scl_pull    (scl_pull),
    .addr_byte   (addr_byte)
);

// File: tb/bus_wake_responder_bench.sv
module bus_wake_responder_bench;
    localparam int         HALF  = 8;
    localparam logic [6:0] OWN_A = 7'h3A;
    localparam logic [6:0] OWN_B = 7'h00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic core_active = 1'b1;
    logic core_ready = 1'b1;
    logic wake_a, scl_pull_a, sda_pull_a;
    logic wake_b, scl_pull_b, sda_pull_b;
    logic scl_line, sda_line;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    // Wired-AND open-drain bus with two slaves
    assign scl_line = scl_m & ~scl_pull_a & ~scl_pull_b;
    assign sda_line = sda_m & ~sda_pull_a & ~sda_pull_b;

    bus_wake_responder #(.OWN_ADDR(OWN_A)) u_bus_wake_responder (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .core_active(core_active), .core_ready(core_ready),
        .wake_req(wake_a), .scl_pull(scl_pull_a), .sda_pull(sda_pull_a));

    bus_wake_responder #(.OWN_ADDR(OWN_B)) u_bus_wake_responder_zero (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .core_active(core_active), .core_ready(core_ready),
        .wake_req(wake_b), .scl_pull(scl_pull_b), .sda_pull(sda_pull_b));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic hw(input int n = HALF);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b0; hw();
        scl_m = 1'b0; hw();
    endtask

    task automatic do_stop();
        sda_m = 1'b0; hw();
        scl_m = 1'b1; hw();
        sda_m = 1'b1; hw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits, input int wake_after);
        for (int i = 0; i < nbits; i++) begin
            sda_m = b[7-i]; hw();
            scl_m = 1'b1;   hw();
            scl_m = 1'b0;
            if (i == wake_after) core_active = 1'b1;
        end
    endtask

    // Ninth clock; returns whether SDA was low mid-high
    task automatic ninth(output bit acked);
        sda_m = 1'b1; hw();
        scl_m = 1'b1; hw(HALF/2);
        acked = !sda_line;
        hw(HALF/2);
        scl_m = 1'b0; hw();
    endtask

    task automatic frame(input logic [7:0] b, input int wake_after, output bit acked);
        do_start();
        send_bits(b, 8, wake_after);
        ninth(acked);
        do_stop();
    endtask

    initial begin
        bit ack;
        bit seen;
        hw(4);
        rst_n = 1'b1;
        hw(4);
        // R9: reset state
        check(!sda_pull_a && !scl_pull_a && !wake_a, "R9 reset outputs",
              {sda_pull_a, scl_pull_a, wake_a}, 0);

        // R2: a plain SCL edge while halted wakes; clears once core is active
        core_active = 1'b0;
        scl_m = 1'b0; hw();
        check(wake_a == 1'b1, "R2 wake on scl edge", wake_a, 1);
        scl_m = 1'b1; hw();
        check(wake_a == 1'b1, "R2 wake held", wake_a, 1);
        core_active = 1'b1; hw(4);
        check(wake_a == 1'b0, "R2 wake cleared by active", wake_a, 0);

        // R3: halted frame NACKed, then retry acknowledged (R4)
        core_active = 1'b0;
        frame({OWN_A, 1'b0}, -1, ack);
        check(ack == 1'b0, "R3 halted frame nack", ack, 0);
        check(wake_a == 1'b1, "R2 wake after halted frame", wake_a, 1);
        core_active = 1'b1; hw();
        frame({OWN_A, 1'b0}, -1, ack);
        check(ack == 1'b1, "R4 retry ack", ack, 1);

        // R3: core wakes mid-frame, still NACK; the retry is acked
        core_active = 1'b0;
        frame({OWN_A, 1'b1}, 2, ack);
        check(ack == 1'b0, "R3 woke mid-frame nack", ack, 0);
        frame({OWN_A, 1'b1}, -1, ack);
        check(ack == 1'b1, "R4 retry after mid-frame wake", ack, 1);

        // R5: wake byte while halted and while active
        core_active = 1'b0;
        frame(8'h01, -1, ack);
        check(ack == 1'b0, "R5 wake byte halted nack", ack, 0);
        check(wake_a && wake_b, "R5 wake byte raises wake", {wake_a, wake_b}, 3);
        core_active = 1'b1; hw();
        frame(8'h01, -1, ack);
        check(ack == 1'b0, "R5 wake byte active nack", ack, 0);

        // R4 R5 R6: sweep of every byte, core active
        for (int b = 0; b < 256; b++) begin
            bit exp_ack;
            exp_ack = (b[7:1] == OWN_A) || (b[7:1] == OWN_B && b != 1);
            frame(8'(b), -1, ack);
            check(ack == exp_ack, "R6 sweep ack decision", ack, exp_ack);
        end

        // R6: non-matching address while halted
        core_active = 1'b0;
        frame({7'h3B, 1'b0}, -1, ack);
        check(ack == 1'b0, "R6 halted mismatch nack", ack, 0);
        core_active = 1'b1; hw();

        // R1: address clocked with no START gets no ack
        scl_m = 1'b0; hw();
        send_bits({OWN_A, 1'b0}, 8, -1);
        ninth(ack);
        check(ack == 1'b0, "R1 no start no ack", ack, 0);
        do_stop();

        // R8: repeated START mid-address restarts counting
        do_start();
        send_bits({OWN_A, 1'b0}, 4, -1);
        do_start();
        send_bits({OWN_A, 1'b0}, 8, -1);
        ninth(ack);
        check(ack == 1'b1, "R8 repeated start ack", ack, 1);
        do_stop();

        // R8: STOP mid-address returns to idle
        do_start();
        send_bits({OWN_A, 1'b0}, 5, -1);
        do_stop();
        scl_m = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            sda_m = 1'b0;
            for (int c = 0; c < 2*HALF; c++) begin
                scl_m = (c >= HALF);
                @(negedge clk);
                if (sda_pull_a) seen = 1'b1;
            end
            scl_m = 1'b0;
        end
        for (int c = 0; c < 2*HALF; c++) begin
            sda_m = 1'b1;
            scl_m = (c >= HALF);
            @(negedge clk);
            if (sda_pull_a) seen = 1'b1;
        end
        scl_m = 1'b0; hw();
        check(seen == 1'b0, "R8 stop cancels address", seen, 0);
        do_stop();

        // R7: clock stretch after ack while core not ready
        core_ready = 1'b0;
        do_start();
        send_bits({OWN_A, 1'b0}, 8, -1);
        ninth(ack);
        check(ack == 1'b1, "R7 ack before stretch", ack, 1);
        scl_m = 1'b1; hw(4);
        check(scl_line == 1'b0, "R7 scl held low", scl_line, 0);
        check(sda_pull_a == 1'b0, "R9 sda released in stretch", sda_pull_a, 0);
        core_ready = 1'b1; hw(2);
        check(scl_line == 1'b1, "R7 scl released", scl_line, 1);
        hw();
        scl_m = 1'b0; hw();
        do_stop();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule